// File: doc/BRIEF.md
# Byte-Lane Data Memory with Size Control

This block is a synchronous data store addressed by byte. One 2-bit command selects, per clock, between reading a full word and writing one byte, one halfword or one full word. Storage is a parameterised array of 32-bit words split into four 8-bit lanes. A partial write touches only its own lanes, and the other bytes of the word keep their values.

Each command has an alignment rule. If an enabled access breaks that rule, the block raises an error flag for one cycle and leaves both the storage and the read output unchanged. Read data is registered, so it appears after the rising clock edge that samples the read command. Lanes are little-endian: byte offset 0 sits in bits [7:0] of a word.

Top module: `lane_data_ram`

## Requirements
- R1: With `en` high and `cmd` = 00, the word at word index `addr[IDX_W+1:2]` is loaded into `rdata` on the rising edge, provided `addr[1:0]` = 00.
- R2: With `en` high and `cmd` = 01, `wdata[7:0]` is stored in the byte lane chosen by `addr[1:0]`. The other three lanes of that word keep their values.
- R3: With `en` high and `cmd` = 10, `wdata[15:0]` is stored in bits [15:0] of the word when `addr[1]` = 0, and in bits [31:16] when `addr[1]` = 1. The other half of the word is unchanged.
- R4: With `en` high and `cmd` = 11, all 32 bits of `wdata` replace the addressed word.
- R5: The alignment rules are as follows. A word read or word write needs `addr[1:0]` = 00. A halfword write needs `addr[0]` = 0. A byte write is accepted at any offset.
- R6: An enabled access that breaks R5 sets `err` high during the cycle after its edge. It writes no lane, and it leaves `rdata` unchanged. `err` is low after any edge that saw a legal access or no access.
- R7: With `en` low, no lane is written, `rdata` holds its value and `err` is low after the edge.
- R8: A clock edge with `rst_n` low clears every stored word, `rdata` and `err` to zero.
- R9: Address bits above `IDX_W+1` are ignored, so addresses that differ only there refer to the same word. `IDX_W` is log2 of `DEPTH`, which defaults to 64 words.
- R10: Byte lanes are little-endian. Byte offset k occupies bits [8k+7:8k] of the stored word and of `rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Access enable |
| cmd | input | 2 | 00 read word, 01 write byte, 10 write halfword, 11 write word |
| addr | input | 32 | Byte address |
| wdata | input | 32 | Write data, right-justified for byte and halfword writes |
| rdata | output | 32 | Registered read data |
| err | output | 1 | Alignment error seen on the previous edge |

## Verification
Assertions check the following on every cycle:
- the decoder selects exactly one lane for a byte write and an adjacent pair of lanes for a legal halfword write;
- a misaligned request never produces a lane write, and a read never produces one either;
- the read register holds unless a legal read is issued;
- the error flag stays low after an idle cycle.

Whether the right bytes arrive in the right word can only be shown by the bench's scenarios. Its behavioural model covers lane placement for every offset, preservation of neighbouring lanes, address aliasing above the index bits, and rejected writes that leave memory intact. It checks these through later reads.

// File: rtl/lmem_pkg.sv
// Package: shared command encoding and lane geometry for the byte-lane memory.
// Assumes a 32-bit data path made of four 8-bit lanes.
package lmem_pkg;
    localparam int LANES  = 4;
    localparam int LANE_W = 8;
    localparam int DATA_W = LANES * LANE_W;

    typedef enum logic [1:0] {
        CMD_RD_WORD = 2'b00,
        CMD_WR_BYTE = 2'b01,
        CMD_WR_HALF = 2'b10,
        CMD_WR_WORD = 2'b11
    } mem_cmd_e;
endpackage

// File: rtl/lmem_decode.sv
// Module: lmem_decode
// Turns the command and the low two address bits into per-lane write enables,
// a read request and an alignment error. Assumes a 4-lane little-endian word.
module lmem_decode
    import lmem_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [1:0]       cmd,
    input  logic [1:0]       offs,
    output logic [LANES-1:0] lane_we,
    output logic             rd_go,
    output logic             misalign
);
    mem_cmd_e cmd_e;
    logic     bad_align;

    // Classify the command and check its alignment rule.
    always_comb begin
        cmd_e = mem_cmd_e'(cmd);
        unique case (cmd_e)
            CMD_RD_WORD: bad_align = (offs != 2'b00);
            CMD_WR_BYTE: bad_align = 1'b0;
            CMD_WR_HALF: bad_align = offs[0];
            CMD_WR_WORD: bad_align = (offs != 2'b00);
            default:     bad_align = 1'b0;
        endcase
    end

    // Produce lane enables for a legal enabled write.
    always_comb begin
        lane_we = '0;
        if (en && !bad_align) begin
            unique case (cmd_e)
                CMD_WR_BYTE: lane_we = LANES'(1) << offs;
                CMD_WR_HALF: lane_we = offs[1] ? 4'b1100 : 4'b0011;
                CMD_WR_WORD: lane_we = '1;
                default:     lane_we = '0;
            endcase
        end
    end

    // Read request and error flag for this cycle.
    always_comb begin
        rd_go    = en && !bad_align && (cmd_e == CMD_RD_WORD);
        misalign = en && bad_align;
    end

    // R2: a byte write enables exactly one lane.
    assert_byte_one_lane_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && cmd == 2'b01) |-> ($countones(lane_we) == 1));

    // R3: a legal halfword write enables a pair of lanes.
    assert_half_two_lanes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && cmd == 2'b10 && !offs[0]) |-> ($countones(lane_we) == 2));

    // R6: a misaligned request writes nothing and reads nothing.
    assert_misalign_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |-> (lane_we == '0 && !rd_go));

    // R1: a read never writes a lane.
    assert_read_no_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_go |-> (lane_we == '0));
endmodule

// File: rtl/lmem_steer.sv
// Module: lmem_steer
// Replicates right-justified write data across lanes so that any selected lane
// receives the right byte. Assumes byte and halfword data sit in the low bits.
module lmem_steer
    import lmem_pkg::*;
(
    input  logic [1:0]        cmd,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] lane_data
);
    // Replicate the payload according to the access size.
    always_comb begin
        unique case (mem_cmd_e'(cmd))
            CMD_WR_BYTE: lane_data = {LANES{wdata[LANE_W-1:0]}};
            CMD_WR_HALF: lane_data = {(LANES/2){wdata[2*LANE_W-1:0]}};
            default:     lane_data = wdata;
        endcase
    end
endmodule

// File: rtl/lmem_store.sv
// Module: lmem_store
// Word array split into byte lanes, each with its own write enable, plus the
// registered read port. Assumes at most one access per cycle.
module lmem_store
    import lmem_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  idx,
    input  logic [LANES-1:0]  lane_we,
    input  logic [DATA_W-1:0] lane_data,
    input  logic              rd_go,
    output logic [DATA_W-1:0] rdata
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];
        logic [LANE_W-1:0] rd_q;

        // Lane storage: clear on reset, write when this lane is enabled.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int w = 0; w < DEPTH; w++) cells[w] <= '0;
            end else if (lane_we[g]) begin
                cells[idx] <= lane_data[g*LANE_W +: LANE_W];
            end
        end

        // Lane read register: load on a legal read, otherwise hold.
        always_ff @(posedge clk) begin
            if (!rst_n)     rd_q <= '0;
            else if (rd_go) rd_q <= cells[idx];
        end

        assign rdata[g*LANE_W +: LANE_W] = rd_q;
    end

    // R1/R6/R7: the read output moves only after a legal read.
    assert_rdata_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_go |=> $stable(rdata));
endmodule

// File: rtl/lane_data_ram.sv
// Module: lane_data_ram (top)
// Byte-addressed data memory with a 2-bit size command, registered reads and
// an alignment error flag. Assumes synchronous active-low reset; upper address
// bits beyond the word index are ignored.
module lane_data_ram
    import lmem_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        en,
    input  logic [1:0]  cmd,
    input  logic [31:0] addr,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output logic        err
);
    logic [LANES-1:0]  lane_we;
    logic              rd_go;
    logic              misalign;
    logic [DATA_W-1:0] lane_data;
    logic              err_q;

    lmem_decode u_decode (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .cmd      (cmd),
        .offs     (addr[1:0]),
        .lane_we  (lane_we),
        .rd_go    (rd_go),
        .misalign (misalign)
    );

    lmem_steer u_steer (
        .cmd       (cmd),
        .wdata     (wdata),
        .lane_data (lane_data)
    );

    lmem_store #(.DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .idx       (addr[IDX_W+1:2]),
        .lane_we   (lane_we),
        .lane_data (lane_data),
        .rd_go     (rd_go),
        .rdata     (rdata)
    );

    // Error flag: reflects the alignment check of the last edge.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= misalign;
    end

    assign err = err_q;

    // R7: an idle cycle never leaves the error flag set.
    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !err);
endmodule

// File: tb/sim_lane_data_ram.sv
// Bench: behavioural model of the memory, compared after every clock edge.
module sim_lane_data_ram;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [1:0]  cmd = 2'b00;
    logic [31:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        err;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] model [64];
    logic [31:0] exp_rd;
    logic        exp_err;

    always #10 clk = ~clk;

    lane_data_ram u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .cmd(cmd),
        .addr(addr), .wdata(wdata), .rdata(rdata), .err(err)
    );

    task automatic compare(input string tag);
        checks++;
        if (rdata !== exp_rd || err !== exp_err) begin
            errors++;
            $display("FAIL %s: rdata=%h err=%b expected rdata=%h err=%b",
                     tag, rdata, err, exp_rd, exp_err);
        end
    endtask

    // One access: drive at negedge, model at posedge, compare at next negedge.
    task automatic step(input logic e, input logic [1:0] c,
                        input logic [31:0] a, input logic [31:0] d,
                        input string tag);
        int  w;
        logic bad;
        en = e; cmd = c; addr = a; wdata = d;
        @(posedge clk);
        w   = int'(a[7:2]);
        bad = (c == 2'b10) ? a[0] : (c == 2'b01) ? 1'b0 : (a[1:0] != 2'b00);
        exp_err = e && bad;
        if (e && !bad) begin
            case (c)
                2'b00: exp_rd = model[w];
                2'b01: model[w][8*a[1:0] +: 8] = d[7:0];
                2'b10: model[w][16*a[1] +: 16] = d[15:0];
                default: model[w] = d;
            endcase
        end
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: rdata=%h err=%b expected completion", rdata, err);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 64; i++) model[i] = '0;
        exp_rd = '0; exp_err = 1'b0;
        repeat (3) @(negedge clk);
        compare("R8 reset outputs");
        rst_n = 1'b1;

        // R8: memory cleared
        step(1, 2'b00, 32'h0000_0010, '0, "R8 cleared word read");
        // R4 + R1: word write then read
        step(1, 2'b11, 32'h0000_0020, 32'hDEAD_BEEF, "R4 word write");
        step(1, 2'b00, 32'h0000_0020, '0, "R1 word read");
        // R2 + R10: byte lanes, little-endian
        for (int k = 0; k < 4; k++)
            step(1, 2'b01, 32'h0000_0040 + k, 32'hFFFF_FF10 + k, "R2 byte write");
        step(1, 2'b00, 32'h0000_0040, '0, "R10 byte lane order");
        step(1, 2'b01, 32'h0000_0022, 32'h0000_0055, "R2 byte into word");
        step(1, 2'b00, 32'h0000_0020, '0, "R2 neighbours kept");
        // R3: halfword both halves
        step(1, 2'b10, 32'h0000_0032, 32'hAAAA_1234, "R3 upper half write");
        step(1, 2'b00, 32'h0000_0030, '0, "R3 upper half read");
        step(1, 2'b10, 32'h0000_0030, 32'h0000_5678, "R3 lower half write");
        step(1, 2'b00, 32'h0000_0030, '0, "R3 lower half read");
        // R5 + R6: misaligned accesses
        step(1, 2'b10, 32'h0000_0031, 32'hFFFF_FFFF, "R6 odd halfword");
        step(1, 2'b11, 32'h0000_0032, 32'hFFFF_FFFF, "R6 unaligned word write");
        step(1, 2'b00, 32'h0000_0021, '0, "R6 unaligned read holds rdata");
        step(1, 2'b00, 32'h0000_0030, '0, "R6 memory untouched");
        step(1, 2'b01, 32'h0000_0033, 32'h0000_0099, "R5 byte any offset");
        // R7: disabled access
        step(0, 2'b11, 32'h0000_0030, 32'h1111_1111, "R7 disabled write");
        step(0, 2'b00, 32'h0000_0020, '0, "R7 disabled read");
        step(1, 2'b00, 32'h0000_0030, '0, "R7 memory untouched");
        // R9: aliasing above the index bits
        step(1, 2'b11, 32'hF000_0104, 32'hCAFE_F00D, "R9 high-address write");
        step(1, 2'b00, 32'h0000_0004, '0, "R9 alias read");
        // mixed traffic
        for (int n = 0; n < 400; n++)
            step(($urandom % 5) != 0, 2'($urandom), $urandom, $urandom, "R1 mixed traffic");
        for (int i = 0; i < 64; i++)
            step(1, 2'b00, 32'(i * 4), '0, "R1 final sweep");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule